// File: doc/BRIEF.md
# Serial Receive Word Capture

This block collects one 13-bit two's complement sample from a three-wire serial input: a frame enable, a bit clock and a data line. A rising edge on the frame enable arms a new word. Each later falling edge of the bit clock shifts one data bit into a shift register. The sign bit arrives first and the least significant bit arrives last. Once 13 bits are in, the word is complete and any further bit-clock edges are ignored until the enable rises again.

The completed word does not reach the output directly. It is copied into a holding register only when the frame sequencer pulses a one-cycle latch strobe. The converter stage downstream reads that holding register. A strobe that comes before the word is complete leaves the holding register unchanged. A strobe in the mode that converts in one direction only (analog-to-digital) also leaves it unchanged.

The three serial pins are asynchronous to the system clock, so they pass through a synchronizer before their edges are detected. The input side is framed by enable and clock rather than valid/ready, so it cannot apply back-pressure: a bit is lost if the sender does not keep to the framing rules. The output is a level held between strobes, with no handshake, and the reader samples it whenever it needs to.

Top module: `rxw_capture`

## Requirements
- R1: A data bit is taken from `rx_dat_i` at a falling edge of `rx_clk_i`, using the value the data line holds when that edge is sampled. Rising edges of `rx_clk_i` capture nothing.
- R2: The first bit after an enable rising edge becomes bit 12 (the sign) of the word, and the 13th bit becomes bit 0.
- R3: Only the first 13 falling edges after an `rx_en_i` rising edge capture data. Later edges are ignored. Falling edges seen before any enable rise after reset are also ignored.
- R4: `word_done_o` goes high once the 13th bit has been shifted in and stays high until the next `rx_en_i` rising edge, which clears it. A fresh rising edge discards any partial word and restarts the count at zero.
- R5: In the cycle where `latch_stb_i` is high, `word_done_o` is high and `adc_only_i` is low, the shifted word is copied to `dac_word_o`. In every other cycle `dac_word_o` holds its value, including when the strobe comes before 13 bits have been captured.
- R6: While `adc_only_i` is high, a strobe does not update `dac_word_o`.
- R7: With the default two synchronizer stages, a bit-clock falling edge that is present before system clock edge k takes effect at clock edge k+2. That edge updates the shift register and, for the 13th bit, `word_done_o`. `dac_word_o` changes at the clock edge that samples the strobe.
- R8: A synchronous active-low reset clears the shift register, the bit counter, `word_done_o` and `dac_word_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en_i | input | 1 | Frame enable; a rising edge starts a word (asynchronous) |
| rx_clk_i | input | 1 | Bit clock; data is sampled on its falling edge (asynchronous) |
| rx_dat_i | input | 1 | Serial data, sign bit first (asynchronous) |
| latch_stb_i | input | 1 | One-cycle strobe from the frame sequencer that loads the holding register |
| adc_only_i | input | 1 | High selects the analog-to-digital-only mode; the holding register is frozen |
| word_done_o | output | 1 | All 13 bits of the current word have been captured |
| dac_word_o | output | 13 | Holding register read by the converter |

## Verification
A bit-clock edge reaches the shift register and the completion flag three system clock edges after it is driven. Each of the two synchronizer stages adds one edge, and the edge-detect compare adds the third. The holding register reflects a strobe at the first edge that samples it. The bench drives on falling system clock edges and samples on falling edges too. It holds each serial level for four clocks and waits several clocks after the last bit before it looks at the completion flag. It reads the holding register one clock after the strobe. One directed test samples the completion flag two clocks and three clocks after the 13th falling edge, which pins down the three-edge latency exactly.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  // Capture state of the shift path.
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,  // no enable edge seen since reset
    RX_SHIFT = 2'd1,  // collecting bits
    RX_FULL  = 2'd2   // word complete, further bits dropped
  } rx_state_e;

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rxw_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins. It also
// presents the previous synchronized level, so the caller can detect edges.
module rxw_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q[0] <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_q <= '0;
        end else begin
          stg_q[0] <= pin_i;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[LAST];
  end

  assign lvl_o  = stg_q[LAST];
  assign prev_o = prev_q;

endmodule

// File: rtl/rxw_shift_ctr.sv
// Bit counter and MSB-first shift register for one framed word.
module rxw_shift_ctr
  import rxw_pkg::*;
#(
  parameter int unsigned WORD_W = 13,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,   // enable rising edge
  input  logic              bit_stb_i, // bit clock falling edge
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  rx_state_e         state_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      // A new frame always restarts; a coincident edge is the first bit.
      if (bit_stb_i) begin
        sh_q    <= WORD_W'(bit_i);
        cnt_q   <= ONE;
        state_q <= (WORD_W == 1) ? RX_FULL : RX_SHIFT;
      end else begin
        sh_q    <= '0;
        cnt_q   <= '0;
        state_q <= RX_SHIFT;
      end
    end else if (bit_stb_i && state_q == RX_SHIFT) begin
      sh_q  <= {sh_q[WORD_W-2:0], bit_i};
      cnt_q <= cnt_q + ONE;
      if (cnt_q == LAST_IDX) state_q <= RX_FULL;
    end
  end

  assign word_o = sh_q;
  assign cnt_o  = cnt_q;
  assign done_o = (state_q == RX_FULL);

endmodule

// File: rtl/rxw_hold_latch.sv
// Holding register loaded by the sequencer strobe.
module rxw_hold_latch #(
  parameter int unsigned WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);

  logic [WORD_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/rxw_capture.sv
module rxw_capture
  import rxw_pkg::*;
#(
  parameter int unsigned WORD_W      = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic              rx_clk_i,
  input  logic              rx_dat_i,
  input  logic              latch_stb_i,
  input  logic              adc_only_i,
  output logic              word_done_o,
  output logic [WORD_W-1:0] dac_word_o
);

  localparam int unsigned CNT_W = cnt_width(WORD_W);
  localparam int unsigned PIN_N = 3;
  localparam int unsigned P_DAT = 0;
  localparam int unsigned P_CLK = 1;
  localparam int unsigned P_EN  = 2;

  logic [PIN_N-1:0]  pin_lvl;
  logic [PIN_N-1:0]  pin_prev;
  logic              en_rise;
  logic              clk_fall;
  logic              unused_dat_prev;
  logic [WORD_W-1:0] shift_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              word_done;
  logic              latch_load;

  rxw_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({rx_en_i, rx_clk_i, rx_dat_i}),
    .lvl_o  (pin_lvl),
    .prev_o (pin_prev)
  );

  assign en_rise         = pin_lvl[P_EN] & ~pin_prev[P_EN];
  assign clk_fall        = ~pin_lvl[P_CLK] & pin_prev[P_CLK];
  assign unused_dat_prev = pin_prev[P_DAT];

  rxw_shift_ctr #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (en_rise),
    .bit_stb_i (clk_fall),
    .bit_i     (pin_lvl[P_DAT]),
    .word_o    (shift_word),
    .cnt_o     (bit_cnt),
    .done_o    (word_done)
  );

  assign latch_load = latch_stb_i & word_done & ~adc_only_i;

  rxw_hold_latch #(
    .WORD_W (WORD_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (latch_load),
    .d_i    (shift_word),
    .q_o    (dac_word_o)
  );

  assign word_done_o = word_done;

endmodule

// File: rtl/rxw_capture_chk.sv
module rxw_capture_chk #(
  parameter int unsigned WORD_W = 13,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_rise,
  input logic              clk_fall,
  input logic              latch_stb_i,
  input logic              adc_only_i,
  input logic              word_done_o,
  input logic [WORD_W-1:0] shift_word,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] dac_word_o
);

  // R3: counter never passes the word length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  // R1: completion only follows a bit-clock falling edge
  a_r1_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_done_o) |-> $past(clk_fall));

  // R4: an enable rising edge clears completion
  a_r4_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !word_done_o);

  // R5: qualified strobe copies the shifted word
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb_i && word_done_o && !adc_only_i) |=> dac_word_o == $past(shift_word));

  // R5: otherwise the holding register keeps its value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_stb_i && word_done_o && !adc_only_i) |=> $stable(dac_word_o));

  // R6: one-direction mode freezes the holding register
  a_r6_adc_only: assert property (@(posedge clk) disable iff (!rst_n)
    adc_only_i |=> $stable(dac_word_o));

  // R8: reset clears outputs
  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (dac_word_o == '0 && !word_done_o));

endmodule

bind rxw_capture rxw_capture_chk #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_rise     (en_rise),
  .clk_fall    (clk_fall),
  .latch_stb_i (latch_stb_i),
  .adc_only_i  (adc_only_i),
  .word_done_o (word_done_o),
  .shift_word  (shift_word),
  .bit_cnt     (bit_cnt),
  .dac_word_o  (dac_word_o)
);

// File: tb/rxw_capture_tb.sv
module rxw_capture_tb;

  localparam int unsigned W = 13;
  localparam int unsigned NVEC = 8;

  // Vector layout: [19] adc_only, [18:14] bit count, [13] spare, [12:0] word
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 5'd13, 1'b0, 13'h1ABC},
    {1'b0, 5'd13, 1'b0, 13'h0001},
    {1'b0, 5'd16, 1'b0, 13'h1000},
    {1'b0, 5'd9,  1'b0, 13'h0F0F},
    {1'b1, 5'd13, 1'b0, 13'h0555},
    {1'b0, 5'd13, 1'b0, 13'h1FFF},
    {1'b0, 5'd15, 1'b0, 13'h0AAA},
    {1'b0, 5'd0,  1'b0, 13'h0123}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_en = 1'b0;
  logic         rx_clk = 1'b1;
  logic         rx_dat = 1'b0;
  logic         latch_stb = 1'b0;
  logic         adc_only = 1'b0;
  logic         word_done;
  logic [W-1:0] dac_word;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] exp_word = '0;

  always #10 clk = ~clk;

  rxw_capture u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en),
    .rx_clk_i    (rx_clk),
    .rx_dat_i    (rx_dat),
    .latch_stb_i (latch_stb),
    .adc_only_i  (adc_only),
    .word_done_o (word_done),
    .dac_word_o  (dac_word)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic one_bit(input logic b);
    rx_dat = b;
    waitc(4);
    rx_clk = 1'b0;
    waitc(4);
    rx_clk = 1'b1;
  endtask

  // Frame a word: enable rise, nbits bits (extras are junk), enable low.
  task automatic send_word(input logic [W-1:0] w, input int nbits);
    rx_en = 1'b1;
    waitc(4);
    for (int i = 0; i < nbits; i++) one_bit((i < W) ? w[W-1-i] : ~w[0]);
    waitc(4);
    rx_en = 1'b0;
    waitc(6);
  endtask

  task automatic strobe();
    latch_stb = 1'b1;
    waitc(1);
    latch_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    waitc(4);
    // R8: state after reset
    check(dac_word == '0, "R8 reset word", 32'(dac_word), 0);
    check(!word_done, "R8 reset done", 32'(word_done), 0);
    rst_n = 1'b1;
    waitc(4);

    // Vector loop: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [W-1:0] w;
      int nb;
      logic ao;
      w  = VEC[v][12:0];
      nb = int'(VEC[v][18:14]);
      ao = VEC[v][19];
      adc_only = ao;
      send_word(w, nb);
      check(word_done == (nb >= W), "R3/R4 done after frame", 32'(word_done),
            32'(nb >= W));
      strobe();
      if (nb >= W && !ao) exp_word = w;
      check(dac_word == exp_word, "R2/R5/R6 holding word", 32'(dac_word),
            32'(exp_word));
      adc_only = 1'b0;
    end

    // R4: a fresh enable rise discards a partial word
    rx_en = 1'b1;
    waitc(4);
    for (int i = 0; i < 5; i++) one_bit(1'b1);
    waitc(4);
    rx_en = 1'b0;
    waitc(4);
    send_word(13'h0246, 13);
    strobe();
    check(dac_word == 13'h0246, "R4 restart on new enable", 32'(dac_word), 32'h0246);

    // R7: completion latency after the 13th falling edge
    rx_en = 1'b1;
    waitc(4);
    for (int i = 0; i < 12; i++) one_bit(13'h1357 >> (12 - i));
    rx_dat = 1'b1;
    waitc(4);
    rx_clk = 1'b0;
    waitc(2);
    check(!word_done, "R7 done not before third edge", 32'(word_done), 0);
    waitc(1);
    check(word_done, "R7 done at third edge", 32'(word_done), 1);
    waitc(4);
    rx_clk = 1'b1;
    waitc(4);
    rx_en = 1'b0;
    waitc(4);
    strobe();
    check(dac_word == 13'h1357, "R7/R1 word after latency test", 32'(dac_word), 32'h1357);

    // R8: mid-run reset clears everything
    rst_n = 1'b0;
    waitc(2);
    rst_n = 1'b1;
    waitc(2);
    check(dac_word == '0, "R8 reset clears word", 32'(dac_word), 0);
    check(!word_done, "R8 reset clears done", 32'(word_done), 0);

    // R3: bit-clock edges with no enable rise are ignored
    for (int i = 0; i < 13; i++) one_bit(1'b1);
    waitc(6);
    check(!word_done, "R3 no capture without enable", 32'(word_done), 0);
    strobe();
    check(dac_word == '0, "R3 holding word untouched", 32'(dac_word), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule